// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits between an interrupt arbiter and the processor core. It accepts a winning request level from the arbiter. It then runs one acknowledge bus cycle in CPU space and turns the cycle's outcome into a 16-bit vector address for the core. The acknowledge cycle places all ones on the upper address bits and the accepted level on bits 3:1, sets bit 0, and drives the function code to CPU space. The cycle can end in three ways. A data acknowledge means the device has put an 8-bit vector number on the data bus. An autovector acknowledge means the vector number is taken from the level. A programmable timeout ends the cycle as spurious.

A built-in chip-select comparator watches the block's own acknowledge cycles. When it is enabled and its programmed level matches, it raises a select strobe towards the interrupting device. It can also end the cycle itself, with either a data acknowledge or an autovector acknowledge. The final address is the vector base plus twice the vector number, modulo 2^16.

Both the request input and the result output use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A result is offered with `vec_valid`, and its fields stay unchanged until the clock edge where `vec_ready` is also high. Back-pressure on the result holds the sequencer busy, so no new request is taken during that time.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, req_ready is 1 and vec_valid, bus_rd and iack_cs are 0.
- R2: A request is taken when req_valid and req_ready are both high. From that edge until the result is taken, req_ready is 0.
- R3: While bus_rd is 1, bus_fc is 3'b111 (CPU space) and bus_addr equals {20'hFFFFF, level[2:0], 1'b1}.
- R4: When a data acknowledge (ext_dack, or the internal one) is sampled while waiting for termination, the vector number is bus_data from that same clock edge and vec_spurious is 0.
- R5: An autovector acknowledge gives vector number 8'h18 + level, with vec_spurious 0.
- R6: If a data acknowledge and an autovector acknowledge are sampled on the same edge, the data acknowledge wins.
- R7: vec_addr equals vbr + {vec_num, 1'b0}, taken modulo 2^16.
- R8: If no termination arrives during timeout_lim+1 clocks of waiting, the result is vector number 8'h18 with vec_spurious 1.
- R9: iack_cs is 1 during the acknowledge cycle exactly when cs_en is 1 and cs_level equals the accepted level. In that case the block ends the cycle itself, with a data acknowledge when cs_avec is 0 and an autovector acknowledge when cs_avec is 1.
- R10: Once vec_valid is 1, it and vec_addr, vec_num and vec_spurious stay unchanged until a clock edge with vec_ready high.
- R11: Acknowledges that arrive in the first cycle of the bus cycle, before the wait state, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Arbiter has a winning level |
| req_ready | output | 1 | Sequencer can take a request |
| req_level | input | 3 | Winning interrupt level |
| vbr | input | 16 | Vector base address |
| timeout_lim | input | 8 | Wait clocks before a spurious result |
| cs_en | input | 1 | Enable the internal chip-select |
| cs_level | input | 3 | Level that the chip-select responds to |
| cs_avec | input | 1 | Chip-select termination kind: 0 data, 1 autovector |
| bus_rd | output | 1 | Acknowledge read cycle active |
| bus_fc | output | 3 | Function code (CPU space while active) |
| bus_addr | output | 24 | Acknowledge cycle address |
| iack_cs | output | 1 | Select strobe towards the interrupting device |
| bus_data | input | 8 | Vector number byte from the device |
| ext_dack | input | 1 | External data acknowledge |
| ext_avec | input | 1 | External autovector acknowledge |
| vec_valid | output | 1 | Result available |
| vec_ready | input | 1 | Core takes the result |
| vec_addr | output | 16 | Formed vector address |
| vec_num | output | 8 | Resolved vector number |
| vec_spurious | output | 1 | Cycle ended by timeout |

## Verification
The hardest case to reach from the ports is a termination that arrives in the first bus cycle and is gone again before the wait state. To produce it, the device responder pulses ext_dack on the first falling edge at which it sees bus_rd and clears it one cycle later. The run must then end in the spurious timeout. The case where both acknowledges arrive on the same edge, and the wrap of the address sum past 16'hFFFF, are driven the same way: the responder is set up for each transaction before the request is issued.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DRIVE, ST_WAIT, ST_LATCH, ST_DONE
  } ack_state_t;

  localparam logic [7:0] AUTOVEC_BASE = 8'h18;
  localparam logic [7:0] SPURIOUS_NUM = 8'h18;
  localparam logic [2:0] FC_CPU_SPACE = 3'b111;
endpackage

// File: rtl/iack_cs_cmp.sv
module iack_cs_cmp #(
  parameter int AW = 24,
  parameter int LW = 3
) (
  input  logic          cyc_on,
  input  logic          wait_ph,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    fc,
  input  logic          en,
  input  logic [LW-1:0] lvl,
  input  logic          avec_mode,
  output logic          sel,
  output logic          int_dack,
  output logic          int_avec
);
  localparam int HI_W = AW - LW - 1;

  logic hi_ones, lvl_hit;

  always_comb begin
    hi_ones  = &addr[AW-1:LW+1];
    lvl_hit  = (addr[LW:1] == lvl) && addr[0];
    sel      = cyc_on && en && hi_ones && lvl_hit && (fc == irq_ack_pkg::FC_CPU_SPACE);
    int_dack = sel && wait_ph && !avec_mode;
    int_avec = sel && wait_ph && avec_mode;
  end

  always_comb begin
    if (HI_W < 1) $error("address too narrow");
  end
endmodule

// File: rtl/iack_timer.sv
module iack_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [CW-1:0] lim,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run && !clear && !expired |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/iack_vec_calc.sv
module iack_vec_calc #(
  parameter int VW = 16,
  parameter int NW = 8
) (
  input  logic [VW-1:0] base,
  input  logic [NW-1:0] num,
  output logic [VW-1:0] addr
);
  localparam int PAD = VW - NW - 1;

  logic [VW-1:0] disp;

  generate
    if (PAD > 0) begin : g_pad
      assign disp = {{PAD{1'b0}}, num, 1'b0};
    end else begin : g_trunc
      assign disp = {num[VW-2:0], 1'b0};
    end
  endgenerate

  assign addr = base + disp;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int AW = 24,
  parameter int VW = 16,
  parameter int NW = 8,
  parameter int LW = 3,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [LW-1:0] req_level,
  input  logic [VW-1:0] vbr,
  input  logic [TW-1:0] timeout_lim,
  input  logic          cs_en,
  input  logic [LW-1:0] cs_level,
  input  logic          cs_avec,
  output logic          bus_rd,
  output logic [2:0]    bus_fc,
  output logic [AW-1:0] bus_addr,
  output logic          iack_cs,
  input  logic [NW-1:0] bus_data,
  input  logic          ext_dack,
  input  logic          ext_avec,
  output logic          vec_valid,
  input  logic          vec_ready,
  output logic [VW-1:0] vec_addr,
  output logic [NW-1:0] vec_num,
  output logic          vec_spurious
);
  import irq_ack_pkg::*;

  localparam int HI_W = AW - LW - 1;

  ack_state_t    state;
  logic [LW-1:0] lvl_q;
  logic [NW-1:0] num_q;
  logic          spur_q;
  logic [VW-1:0] addr_q;
  logic [VW-1:0] calc_addr;
  logic          in_wait, cs_dack, cs_avec_t, expired;
  logic          dack_any, avec_any;

  assign req_ready = (state == ST_IDLE);
  assign bus_rd    = (state == ST_DRIVE) || (state == ST_WAIT);
  assign in_wait   = (state == ST_WAIT);
  assign bus_fc    = bus_rd ? FC_CPU_SPACE : 3'b000;
  assign bus_addr  = bus_rd ? {{HI_W{1'b1}}, lvl_q, 1'b1} : '0;

  iack_cs_cmp #(.AW(AW), .LW(LW)) i_cs (
    .cyc_on(bus_rd), .wait_ph(in_wait), .addr(bus_addr), .fc(bus_fc),
    .en(cs_en), .lvl(cs_level), .avec_mode(cs_avec),
    .sel(iack_cs), .int_dack(cs_dack), .int_avec(cs_avec_t)
  );

  iack_timer #(.CW(TW)) i_tmr (
    .clk(clk), .rst_n(rst_n), .clear(!in_wait), .run(in_wait),
    .lim(timeout_lim), .expired(expired)
  );

  iack_vec_calc #(.VW(VW), .NW(NW)) i_calc (
    .base(vbr), .num(num_q), .addr(calc_addr)
  );

  assign dack_any = ext_dack || cs_dack;
  assign avec_any = ext_avec || cs_avec_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lvl_q  <= '0;
      num_q  <= '0;
      spur_q <= 1'b0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          lvl_q <= req_level;
          state <= ST_DRIVE;
        end
        ST_DRIVE: state <= ST_WAIT;
        ST_WAIT: begin
          if (dack_any) begin
            num_q  <= bus_data;
            spur_q <= 1'b0;
            state  <= ST_LATCH;
          end else if (avec_any) begin
            num_q  <= AUTOVEC_BASE + NW'(lvl_q);
            spur_q <= 1'b0;
            state  <= ST_LATCH;
          end else if (expired) begin
            num_q  <= SPURIOUS_NUM;
            spur_q <= 1'b1;
            state  <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          addr_q <= calc_addr;
          state  <= ST_DONE;
        end
        ST_DONE: if (vec_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign vec_valid    = (state == ST_DONE);
  assign vec_addr     = addr_q;
  assign vec_num      = num_q;
  assign vec_spurious = spur_q;

  a_r2_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !req_ready);
  a_r3_cpu_space: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (bus_fc == 3'b111) && bus_addr[0] && (&bus_addr[AW-1:LW+1]));
  a_r9_cs_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    iack_cs |-> bus_rd);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr) && $stable(vec_num)
      && $stable(vec_spurious));
  a_r11_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |=> bus_rd);
endmodule

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [2:0]  req_level = '0;
  logic [15:0] vbr = '0;
  logic [7:0]  timeout_lim = 8'd6;
  logic        cs_en = 1'b0, cs_avec = 1'b0;
  logic [2:0]  cs_level = '0;
  logic        bus_rd, iack_cs;
  logic [2:0]  bus_fc;
  logic [23:0] bus_addr;
  logic [7:0]  bus_data = '0;
  logic        ext_dack = 1'b0, ext_avec = 1'b0;
  logic        vec_valid, vec_ready = 1'b0, vec_spurious;
  logic [15:0] vec_addr;
  logic [7:0]  vec_num;

  int total = 0, bad = 0, done_cnt = 0, cyc = 0, ticks = 0, rdy_pat = 0;
  int kind = 2, dly = 1;
  logic [7:0] dev_byte = '0;
  logic [24:0] expq[$];

  always #2 clk = ~clk;

  irq_ack_seq i_irq_ack_seq (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Device responder: kinds 0 data, 1 autovector, 2 silent, 3 both, 4 early pulse, 5 internal cs
  always @(negedge clk) begin
    if (bus_rd) begin
      if (cyc == 0) begin
        chk(bus_addr == {20'hFFFFF, req_level, 1'b1} && bus_fc == 3'b111, "R3",
            {bus_fc, 5'b0, bus_addr}, {3'b111, 5'b0, 20'hFFFFF, req_level, 1'b1});
        chk(iack_cs == (cs_en && cs_level == req_level), "R9 strobe", iack_cs,
            cs_en && cs_level == req_level);
      end
      ext_dack = 1'b0; ext_avec = 1'b0;
      case (kind)
        0: if (cyc >= dly) begin ext_dack = 1'b1; bus_data = dev_byte; end
        1: if (cyc >= dly) ext_avec = 1'b1;
        3: if (cyc >= dly) begin ext_dack = 1'b1; ext_avec = 1'b1; bus_data = dev_byte; end
        4: if (cyc == 0) begin ext_dack = 1'b1; ext_avec = 1'b1; bus_data = dev_byte; end
        5: if (iack_cs) bus_data = dev_byte;
        default: ;
      endcase
      cyc++;
    end else begin
      cyc = 0; ext_dack = 1'b0; ext_avec = 1'b0;
    end
  end

  // Monitor: back-pressure pattern, hold check, scoreboard compare
  logic        stalled = 1'b0;
  logic [24:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      rdy_pat++;
      vec_ready = (rdy_pat % 3) != 0;
      if (vec_valid) begin
        if (stalled)
          chk({vec_spurious, vec_num, vec_addr} == held, "R10", {vec_spurious, vec_num, vec_addr}, held);
        chk(!req_ready, "R2 busy", req_ready, 0);
        if (vec_ready) begin
          logic [24:0] e;
          e = expq.pop_front();
          chk({vec_spurious, vec_num, vec_addr} == e, "R4/R5/R6/R7/R8/R9/R11 result",
              {vec_spurious, vec_num, vec_addr}, e);
          done_cnt++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          held = {vec_spurious, vec_num, vec_addr};
        end
      end
    end
  end

  task automatic run_one(input logic [2:0] lvl, input int k, input logic [7:0] byt, input int d,
                         input logic [15:0] base, input logic [7:0] en, input bit es);
    int target;
    logic [15:0] ea;
    target = done_cnt + 1;
    ea = base + {7'b0, en, 1'b0};
    expq.push_back({es, en, ea});
    @(negedge clk);
    kind = k; dly = d; dev_byte = byt; vbr = base;
    req_level = lvl; req_valid = 1'b1;
    chk(req_ready, "R2 ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 taken", req_ready, 0);
    while (done_cnt < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !vec_valid && !bus_rd && !iack_cs, "R1", {req_ready, vec_valid, bus_rd, iack_cs}, 4'b1000);
    rst_n = 1'b1;
    run_one(3'd2, 0, 8'h40, 1, 16'h1000, 8'h40, 1'b0);   // R4 R7
    run_one(3'd5, 0, 8'hC3, 3, 16'h0200, 8'hC3, 1'b0);   // R4 delayed
    run_one(3'd7, 1, 8'h00, 1, 16'h0000, 8'h1F, 1'b0);   // R5
    run_one(3'd1, 1, 8'h00, 2, 16'h0100, 8'h19, 1'b0);   // R5
    run_one(3'd4, 3, 8'h77, 1, 16'h0000, 8'h77, 1'b0);   // R6
    run_one(3'd3, 2, 8'h00, 1, 16'h0800, 8'h18, 1'b1);   // R8
    run_one(3'd6, 4, 8'h55, 0, 16'h0000, 8'h18, 1'b1);   // R11
    run_one(3'd2, 0, 8'h20, 1, 16'hFFF0, 8'h20, 1'b0);   // R7 wrap
    cs_en = 1'b1; cs_level = 3'd3; cs_avec = 1'b0;
    run_one(3'd3, 5, 8'h9A, 0, 16'h0400, 8'h9A, 1'b0);   // R9 internal data ack
    cs_avec = 1'b1;
    run_one(3'd3, 5, 8'h9A, 0, 16'h0400, 8'h1B, 1'b0);   // R9 internal autovector
    run_one(3'd5, 2, 8'h00, 0, 16'h0000, 8'h18, 1'b1);   // R9 level mismatch -> no strobe
    cs_en = 1'b0;
    timeout_lim = 8'd0;
    run_one(3'd1, 2, 8'h00, 0, 16'h0002, 8'h18, 1'b1);   // R8 zero limit
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", ticks);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule